// File: doc/BRIEF.md
# Serial Register-Access Slave for a Control Register Bank

This block is a two-wire bus slave. A host reads and writes a bank of 64 byte-wide control registers through it. SCL and SDA reach the block already synchronized to the system clock. The block finds START, repeated START and STOP conditions on the bus. It answers only to its fixed 7-bit device address (0x44), which makes 0x88 the write address byte and 0x89 the read address byte. It pulls SDA low to acknowledge and to send read data. The `sda_oe` output means "pull the line low", and the pad and pull-up resistor outside the block build the open-drain bus from it.

In a write transfer, the first byte after the address byte loads an internal sub-address pointer. Each byte after that is stored at the pointer, and the pointer then steps forward by one. To read, the host first writes the pointer, then issues a repeated START with the read address and clocks bytes out. The pointer also steps forward after every byte read. It wraps from 63 to 0. Two parameter masks shape the bank. One marks reserved locations, which ignore writes and read as zero. The other marks read-only bits, which always show the value on `ro_data`. The current value of every register is driven on `ctrl_out` for the rest of the chip.

The bus controller is a state machine with these states: IDLE, ADDR (shifting the address byte), ADDR_ACK, PTR (shifting the sub-address), PTR_ACK, WDATA (shifting a write byte), WDATA_ACK, RDATA (driving a read byte), RDATA_ACK (sampling the host's acknowledge) and IGNORE. The transitions are:
- A STOP from any state goes to IDLE. A START from any state goes to ADDR.
- ADDR goes to ADDR_ACK when the address matches, or to IGNORE when it does not.
- ADDR_ACK goes to RDATA for a read or to PTR for a write.
- PTR goes to PTR_ACK, and PTR_ACK goes to WDATA.
- WDATA goes to WDATA_ACK, and WDATA_ACK goes back to WDATA.
- RDATA goes to RDATA_ACK. RDATA_ACK goes to RDATA when the host acknowledges, or to IGNORE when it does not.

The machine moves to a new state on the falling SCL edge that closes a byte or an acknowledge bit.

Top module: `i2c_reg_slave`

## Requirements
- R1: The block pulls SDA low during the ninth clock after an address byte whose upper seven bits equal 0x44 (0x88 write, 0x89 read). For any other address it never drives SDA, and it ignores the following bytes until the next START.
- R2: In a write transfer, the first byte after the address byte loads the pointer from its low 6 bits. It is acknowledged and is not stored in any register.
- R3: Each later write byte is acknowledged, stored at the pointer location, and the pointer then increments by one.
- R4: A repeated START without a STOP in between is accepted. A following read returns the register at the pointer, most significant bit first, and the block changes its SDA drive only while SCL is low.
- R5: During a read the pointer increments after each byte, so consecutive bytes come from consecutive registers.
- R6: The pointer wraps from address 63 to address 0.
- R7: Reserved locations (default: addresses 48 to 63) ignore writes and read back as 0x00.
- R8: Read-only bits (default: all of address 0 and bits 7:4 of address 1) always show the matching `ro_data` bits, and host writes leave them unchanged.
- R9: After the host does not acknowledge a read byte, the block releases SDA and drives nothing more until the next START or STOP.
- R10: A STOP returns the block to idle and releases SDA. Bytes clocked after a STOP without a new START are not acknowledged.
- R11: After reset, SDA is released and every writable register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Synchronized bus clock level |
| sda_in | input | 1 | Synchronized bus data level |
| sda_oe | output | 1 | 1 pulls SDA low |
| ro_data | input | NUM_REGS*8 | Internally supplied values for read-only bits, byte i at [8i+7:8i] |
| ctrl_out | output | NUM_REGS*8 | Current register contents, byte i at [8i+7:8i] |

## Verification
A corrupted pointer shows at the ports on the next read byte: the wrong register's data appears, or consecutive reads skip or repeat a value. A state machine stuck in the wrong phase appears within one byte time. It shows as a missing or extra acknowledge in the ninth clock, as data driven while the host expects to drive, or as SDA still held low after a STOP. A store that writes through a mask shows directly on `ctrl_out` and in the read-back byte of the same transaction sequence.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_IGNORE
    } bus_state_t;

    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda_in;
        end
    end

    always_comb begin
        scl_rise  = scl & ~scl_q;
        scl_fall  = ~scl & scl_q;
        start_det = scl & scl_q & sda_q & ~sda_in;
        stop_det  = scl & scl_q & ~sda_q & sda_in;
    end

endmodule

// File: rtl/i2c_bus_fsm.sv
module i2c_bus_fsm
    import i2c_reg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h44,
    parameter int         AW       = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          sda_in,
    input  logic [7:0]    rd_data,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic [AW-1:0] ptr,
    output logic          sda_oe
);
    bus_state_t state, state_nx;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic       rw_bit;
    logic       host_ack;
    logic       byte_end;

    assign byte_end = scl_fall && (bit_cnt == BITS_PER_BYTE);

    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR:      if (byte_end)
                                  state_nx = (shreg[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall)
                                  state_nx = rw_bit ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_end) state_nx = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:     if (byte_end) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_RDATA:     if (byte_end) state_nx = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall)
                                  state_nx = host_ack ? ST_RDATA : ST_IGNORE;
                ST_IGNORE:    state_nx = ST_IGNORE;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            rw_bit   <= 1'b0;
            host_ack <= 1'b0;
            ptr      <= '0;
        end else begin
            if (start_det || (state_nx != state)) begin
                bit_cnt <= '0;
            end else if (scl_rise && bit_cnt != BITS_PER_BYTE) begin
                bit_cnt <= bit_cnt + 4'd1;
            end

            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) shreg <= {shreg[6:0], sda_in};
                    if (state == ST_ADDR && byte_end) rw_bit <= shreg[0];
                    if (state == ST_PTR && byte_end) ptr <= shreg[AW-1:0];
                    if (state == ST_WDATA && byte_end) ptr <= ptr + AW'(1);
                end
                ST_ADDR_ACK: begin
                    if (scl_fall && rw_bit) shreg <= rd_data;
                end
                ST_RDATA: begin
                    if (byte_end) ptr <= ptr + AW'(1);
                    else if (scl_fall) shreg <= {shreg[6:0], 1'b0};
                end
                ST_RDATA_ACK: begin
                    if (scl_rise) host_ack <= ~sda_in;
                    if (scl_fall && host_ack) shreg <= rd_data;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        sda_oe  = 1'b0;
        wr_en   = 1'b0;
        wr_data = shreg;
        unique case (state)
            ST_ADDR_ACK, ST_PTR_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~shreg[7];
            ST_WDATA: wr_en  = byte_end;
            default: ;
        endcase
    end

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int                      NUM_REGS  = 64,
    parameter int                      AW        = 6,
    parameter logic [NUM_REGS-1:0]     RSVD_MASK = '0,
    parameter logic [NUM_REGS*8-1:0]   RO_MASK   = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         ptr,
    input  logic [7:0]            wr_data,
    input  logic [NUM_REGS*8-1:0] ro_data,
    output logic [7:0]            rd_data,
    output logic [NUM_REGS*8-1:0] view_flat
);
    logic [7:0] view [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (RSVD_MASK[i]) begin : g_rsvd
            logic unused_ro;
            assign unused_ro = ^ro_data[i*8 +: 8];
            assign view[i]   = 8'h00;
        end else begin : g_live
            localparam logic [7:0] ROM = RO_MASK[i*8 +: 8];
            logic [7:0] store;
            always_ff @(posedge clk) begin
                if (rst) begin
                    store <= 8'h00;
                end else if (wr_en && ptr == AW'(i)) begin
                    store <= wr_data & ~ROM;
                end
            end
            assign view[i] = (ro_data[i*8 +: 8] & ROM) | (store & ~ROM);
        end
        assign view_flat[i*8 +: 8] = view[i];
    end

    assign rd_data = view[ptr];

endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
    parameter logic [6:0]            DEV_ADDR  = 7'h44,
    parameter int                    NUM_REGS  = 64,
    parameter logic [NUM_REGS-1:0]   RSVD_MASK = {16'hFFFF, {(NUM_REGS-16){1'b0}}},
    parameter logic [NUM_REGS*8-1:0] RO_MASK   = {{(NUM_REGS*8-16){1'b0}}, 16'hF0FF}
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  scl,
    input  logic                  sda_in,
    output logic                  sda_oe,
    input  logic [NUM_REGS*8-1:0] ro_data,
    output logic [NUM_REGS*8-1:0] ctrl_out
);
    localparam int AW = $clog2(NUM_REGS);

    logic          scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [7:0]    wr_data, rd_data;
    logic [AW-1:0] ptr;

    i2c_bus_events u_events (
        .clk       (clk),
        .rst       (rst),
        .scl       (scl),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_bus_fsm #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_in    (sda_in),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .ptr       (ptr),
        .sda_oe    (sda_oe)
    );

    i2c_reg_bank #(
        .NUM_REGS  (NUM_REGS),
        .AW        (AW),
        .RSVD_MASK (RSVD_MASK),
        .RO_MASK   (RO_MASK)
    ) u_bank (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .ptr       (ptr),
        .wr_data   (wr_data),
        .ro_data   (ro_data),
        .rd_data   (rd_data),
        .view_flat (ctrl_out)
    );

endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
    parameter logic [6:0] DEV_ADDR = 7'h44,
    parameter int         AW       = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          scl,
    input logic          sda_in,
    input logic          sda_oe,
    input logic          wr_en,
    input logic [AW-1:0] ptr
);
    logic       c_scl_q, c_sda_q;
    logic [3:0] c_cnt;
    logic [7:0] c_addr;
    logic       c_start, c_stop, c_rise;

    assign c_start = scl & c_scl_q & c_sda_q & ~sda_in;
    assign c_stop  = scl & c_scl_q & ~c_sda_q & sda_in;
    assign c_rise  = scl & ~c_scl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            c_scl_q <= 1'b1;
            c_sda_q <= 1'b1;
            c_cnt   <= 4'd0;
            c_addr  <= 8'h00;
        end else begin
            c_scl_q <= scl;
            c_sda_q <= sda_in;
            if (c_start) begin
                c_cnt  <= 4'd0;
                c_addr <= 8'h00;
            end else if (c_rise && c_cnt != 4'd9) begin
                c_cnt <= c_cnt + 4'd1;
                if (c_cnt < 4'd8) c_addr <= {c_addr[6:0], sda_in};
            end
        end
    end

    a_r1_no_ack_foreign: assert property (@(posedge clk) disable iff (rst)
        (c_cnt == 4'd8 && c_addr[7:1] != DEV_ADDR) |-> !sda_oe);

    a_r4_drive_moves_scl_low: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl);

    a_r10_stop_release: assert property (@(posedge clk) disable iff (rst)
        c_stop |=> !sda_oe);

    a_r3_ptr_steps_after_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ptr == $past(ptr) + AW'(1)));

    a_r3_single_write_per_byte: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.DEV_ADDR(DEV_ADDR), .AW(AW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .scl    (scl),
    .sda_in (sda_in),
    .sda_oe (sda_oe),
    .wr_en  (wr_en),
    .ptr    (ptr)
);

// File: tb/tb_i2c_reg_slave.sv
module tb_i2c_reg_slave;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 64;
    localparam int Q  = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          scl = 1'b1;
    logic          sda_m = 1'b1;
    logic          sda_oe;
    logic          sda;
    logic [NR*8-1:0] ro_data;
    logic [NR*8-1:0] ctrl_out;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] act_q[$];

    assign sda = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_reg_slave dut (
        .clk      (clk),
        .rst      (rst),
        .scl      (scl),
        .sda_in   (sda),
        .sda_oe   (sda_oe),
        .ro_data  (ro_data),
        .ctrl_out (ctrl_out)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b0; wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq(Q);
        scl = 1'b1;   wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = v[i]; wq(Q);
            scl = 1'b1;   wq(2*Q);
            scl = 1'b0;   wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl = 1'b1;   wq(Q);
        acked = ~sda;
        wq(Q);
        scl = 1'b0;   wq(Q);
    endtask

    task automatic recv_byte(input bit nack);
        logic [7:0] v;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl = 1'b1; wq(Q);
            v[i] = sda;
            wq(Q);
            scl = 1'b0;
        end
        wq(1);
        sda_m = nack; wq(Q);
        scl = 1'b1;   wq(2*Q);
        scl = 1'b0;   wq(1);
        sda_m = 1'b1; wq(Q);
        act_q.push_back(v);
    endtask

    task automatic expect_byte(input logic [7:0] v, input string req);
        exp_q.push_back(v);
        tag_q.push_back(req);
    endtask

    task automatic send_ack(input logic [7:0] v, input bit exp_ack, input string req);
        bit a;
        send_byte(v, a);
        chk(a == exp_ack, req, {7'd0, a}, {7'd0, exp_ack});
    endtask

    task automatic set_ptr(input logic [7:0] p);
        bus_start;
        send_ack(8'h88, 1'b1, "R1");
        send_ack(p, 1'b1, "R2");
    endtask

    always @(negedge clk) begin
        if (act_q.size() > 0) begin
            logic [7:0] a;
            a = act_q.pop_front();
            if (exp_q.size() > 0) begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(a == e, t, a, e);
            end else begin
                chk(1'b0, "SCOREBOARD", a, 8'h00);
            end
        end
    end

    initial begin
        ro_data = '0;
        ro_data[7:0]  = 8'hA5;
        ro_data[15:8] = 8'h3C;
        wq(5);
        chk(sda_oe == 1'b0, "R11", {7'd0, sda_oe}, 8'h00);
        rst = 1'b0;
        wq(5);
        chk(ctrl_out[23:16] == 8'h00, "R11", ctrl_out[23:16], 8'h00);

        // R3: write three bytes from pointer 2
        set_ptr(8'h02);
        send_ack(8'h11, 1'b1, "R3");
        send_ack(8'h22, 1'b1, "R3");
        send_ack(8'h33, 1'b1, "R3");
        bus_stop;
        chk(ctrl_out[23:16] == 8'h11, "R3", ctrl_out[23:16], 8'h11);
        chk(ctrl_out[39:32] == 8'h33, "R3", ctrl_out[39:32], 8'h33);

        // R4, R5, R9: repeated start read, then host NACK
        set_ptr(8'h02);
        bus_start;
        send_ack(8'h89, 1'b1, "R4");
        expect_byte(8'h11, "R4"); recv_byte(1'b0);
        expect_byte(8'h22, "R5"); recv_byte(1'b0);
        expect_byte(8'h33, "R5"); recv_byte(1'b1);
        expect_byte(8'hFF, "R9"); recv_byte(1'b1);
        bus_stop;

        // R2: pointer bytes are never stored
        set_ptr(8'h07); bus_stop;
        set_ptr(8'h09); bus_stop;
        chk(ctrl_out[63:56] == 8'h00, "R2", ctrl_out[63:56], 8'h00);
        chk(ctrl_out[79:72] == 8'h00, "R2", ctrl_out[79:72], 8'h00);

        // R1: foreign addresses and the bytes after them
        bus_start;
        send_ack(8'h90, 1'b0, "R1");
        send_ack(8'h05, 1'b0, "R1");
        bus_stop;
        bus_start;
        send_ack(8'h8A, 1'b0, "R1");
        bus_stop;

        // R7: reserved location 48 after writable 47
        set_ptr(8'h2F);
        send_ack(8'hAA, 1'b1, "R7");
        send_ack(8'hBB, 1'b1, "R7");
        bus_stop;
        chk(ctrl_out[391:384] == 8'h00, "R7", ctrl_out[391:384], 8'h00);
        set_ptr(8'h2F);
        bus_start;
        send_ack(8'h89, 1'b1, "R4");
        expect_byte(8'hAA, "R7"); recv_byte(1'b0);
        expect_byte(8'h00, "R7"); recv_byte(1'b1);
        bus_stop;

        // R8: read-only bits of addresses 0 and 1
        set_ptr(8'h00);
        send_ack(8'h5C, 1'b1, "R8");
        send_ack(8'h6D, 1'b1, "R8");
        bus_stop;
        chk(ctrl_out[7:0] == 8'hA5, "R8", ctrl_out[7:0], 8'hA5);
        set_ptr(8'h00);
        bus_start;
        send_ack(8'h89, 1'b1, "R4");
        expect_byte(8'hA5, "R8"); recv_byte(1'b0);
        expect_byte(8'h3D, "R8"); recv_byte(1'b1);
        bus_stop;

        // R6: pointer wraps from 63 to 0
        set_ptr(8'h3F);
        bus_start;
        send_ack(8'h89, 1'b1, "R4");
        expect_byte(8'h00, "R6"); recv_byte(1'b0);
        expect_byte(8'hA5, "R6"); recv_byte(1'b1);
        bus_stop;

        // R10: bytes after STOP without START are ignored
        wq(2);
        chk(sda_oe == 1'b0, "R10", {7'd0, sda_oe}, 8'h00);
        send_ack(8'h88, 1'b0, "R10");
        send_ack(8'h02, 1'b0, "R10");
        bus_stop;
        chk(ctrl_out[23:16] == 8'h11, "R10", ctrl_out[23:16], 8'h11);

        wq(20);
        chk(exp_q.size() == 0, "SCOREBOARD", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL WATCHDOG: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule